// File: doc/BRIEF.md
# Overcurrent Cycle Truncation Guard

This block sits between a PWM controller and the high-side gate driver of a synchronous buck power stage. It forwards the PWM command to the high-side switch and cuts the command short when an overcurrent comparator trips while the high side is on. Once a cycle has been cut, the high-side command stays off until the controller starts the next PWM period. This protects the switches from a current that keeps rising.

The PWM command is taken as synchronous to `clk`. The comparator flag is asynchronous, so it first passes through a synchronizer chain. A PWM period starts on a rising edge of `pwm_in`. At that edge the block decides whether the period that just ended was cut. Cut periods that follow one another are counted. A single clean period sets the count back to zero. When the count reaches `TRIP_LIMIT`, the block raises `fault_out` and holds it, and `pwm_hs_out` is held off.

Only a supply re-cycle releases the fault. This can be `supply_ok` going low, or the asynchronous power-on reset `por_n`.

Top module: `oc_trunc_guard`

## Requirements
- R1: `oc_trip_async` passes through `SYNC_STAGES` (default 2) flops before use. With the default, a trip sampled at clock edge k first forces `pwm_hs_out` low after edge k+1.
- R2: While `pwm_in` is 1 and the synchronized trip is 1, `pwm_hs_out` is 0 in that same cycle.
- R3: After a cut, `pwm_hs_out` stays 0 for the rest of the PWM period, even once the trip clears. It follows `pwm_in` again from the cycle in which the next rising edge of `pwm_in` is sampled.
- R4: A period boundary is a clock edge where `pwm_in` is 1 and was 0 at the edge before. At each boundary, a period that contained a cut adds one to the count of consecutive cut periods.
- R5: A period without a cut, evaluated at its closing boundary, sets the count to zero. After that, a full `TRIP_LIMIT` run of consecutive cut periods is needed again.
- R6: `fault_out` becomes 1 at the boundary that closes the `TRIP_LIMIT`-th consecutive cut period (default 10), and not before.
- R7: Once `fault_out` is 1, it stays 1 and the count is frozen at its limit. `pwm_hs_out` is 0 for as long as the fault is held.
- R8: `supply_ok` at 0 clears the fault, the count and the cut state at the next clock edge, and keeps `pwm_hs_out` at 0. `por_n` at 0 clears them at once. In both cases `fault_out` stays 0 after `supply_ok` returns.
- R9: A trip while `pwm_in` is 0 is not a cut, and it does not add to the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| supply_ok | input | 1 | Supplies good; low acts as a re-cycle |
| pwm_in | input | 1 | PWM command from the controller, synchronous to clk |
| oc_trip_async | input | 1 | Overcurrent comparator flag, asynchronous |
| pwm_hs_out | output | 1 | Gated high-side PWM command |
| fault_out | output | 1 | Latched overcurrent fault, active high |

## Verification
A wrong cut state shows within one cycle as a `pwm_hs_out` pulse that should not be there, or one that is missing, inside a PWM period. An off-by-one or a missed clear in the period counter shows only at the boundary where the fault should or should not rise. That can be up to `TRIP_LIMIT` periods after the fault lies, so the directed runs place exactly nine and ten cut periods, with a clean period between runs. A stuck or dropped fault shows on the first later PWM high phase, where the output must stay off, and at the first supply re-cycle.

// File: rtl/oc_trunc_pkg.sv
package oc_trunc_pkg;

   // Outcome reported by the gate at every PWM period boundary
   typedef struct packed {
      logic boundary;   // rising edge of pwm_in in this cycle
      logic truncated;  // the period now closing contained a cut
   } cycle_evt_t;

   function automatic int unsigned count_width(input int unsigned limit);
      return (limit < 2) ? 1 : $clog2(limit + 1);
   endfunction

endpackage

// File: rtl/oc_sync.sv
module oc_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);

   if (STAGES < 2) begin : g_bad_stages
      $error("oc_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[i] <= 1'b0;
         else if (i == 0) chain[i] <= d_async;
         else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
   end

   assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/oc_cycle_gate.sv
module oc_cycle_gate
   import oc_trunc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       supply_ok,
   input  logic       pwm_in,
   input  logic       oc_sync,
   input  logic       fault,
   output logic       pwm_hs_out,
   output cycle_evt_t evt
);

   logic pwm_d;
   logic trunc_q;
   logic rise;

   assign rise = pwm_in & ~pwm_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pwm_d <= 1'b0;
      else        pwm_d <= pwm_in;
   end

   // Cut state: set by a trip during the high phase, dropped at a new period
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          trunc_q <= 1'b0;
      else if (!supply_ok) trunc_q <= 1'b0;
      else                 trunc_q <= (rise ? 1'b0 : trunc_q) | (oc_sync & pwm_in);
   end

   assign pwm_hs_out    = pwm_in & supply_ok & ~fault & ~trunc_q & ~oc_sync;
   assign evt.boundary  = rise;
   assign evt.truncated = trunc_q;

   // R3: once cut, the output stays off until a new period begins
   assert_hold_after_cut_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_in && oc_sync && supply_ok) |=> (!pwm_hs_out || rise));

   // R9: a trip during the low phase leaves the cut state untouched
   assert_low_phase_trip_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!pwm_in && !trunc_q && supply_ok) |=> !trunc_q);

endmodule

// File: rtl/oc_trunc_counter.sv
module oc_trunc_counter
   import oc_trunc_pkg::*;
#(
   parameter int unsigned LIMIT = 10
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       supply_ok,
   input  cycle_evt_t evt,
   output logic       fault
);

   localparam int unsigned CNT_W = count_width(LIMIT);

   if (LIMIT < 1) begin : g_bad_limit
      $error("oc_trunc_counter: LIMIT must be at least 1");
   end

   logic fault_q;

   if (LIMIT == 1) begin : g_single
      // A single cut period is enough: no count register needed
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          fault_q <= 1'b0;
         else if (!supply_ok) fault_q <= 1'b0;
         else if (evt.boundary && evt.truncated) fault_q <= 1'b1;
      end
   end else begin : g_count
      localparam logic [CNT_W-1:0] LIM_C = CNT_W'(LIMIT);
      logic [CNT_W-1:0] cnt;
      logic [CNT_W-1:0] cnt_inc;

      assign cnt_inc = (cnt == LIM_C) ? cnt : cnt + 1'b1;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt     <= '0;
            fault_q <= 1'b0;
         end else if (!supply_ok) begin
            cnt     <= '0;
            fault_q <= 1'b0;
         end else if (evt.boundary && !fault_q) begin
            if (evt.truncated) begin
               cnt <= cnt_inc;
               if (cnt_inc == LIM_C) fault_q <= 1'b1;
            end else begin
               cnt <= '0;
            end
         end
      end

      // R5: a clean period clears the run
      assert_clean_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (evt.boundary && !evt.truncated && !fault_q && supply_ok) |=> (cnt == '0));

      // R6: the limit-th cut period raises the fault
      assert_fault_at_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (evt.boundary && evt.truncated && supply_ok && cnt == LIM_C - 1'b1) |=> fault_q);

      // R7: count frozen while the fault is held
      assert_cnt_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (fault_q && supply_ok) |=> $stable(cnt));

      // R8: a supply re-cycle clears the count
      assert_recycle_clears_cnt_R8: assert property (@(posedge clk) disable iff (!rst_n)
         !supply_ok |=> (cnt == '0));
   end

   assign fault = fault_q;

   // R7: fault is sticky while the supplies stay good
   assert_fault_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_q && supply_ok) |=> fault_q);

   // R8: a supply re-cycle releases the fault
   assert_recycle_clears_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !supply_ok |=> !fault_q);

endmodule

// File: rtl/oc_trunc_guard.sv
module oc_trunc_guard
   import oc_trunc_pkg::*;
#(
   parameter int unsigned TRIP_LIMIT  = 10,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic por_n,
   input  logic supply_ok,
   input  logic pwm_in,
   input  logic oc_trip_async,
   output logic pwm_hs_out,
   output logic fault_out
);

   logic       oc_s;
   logic       fault;
   cycle_evt_t evt;

   oc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (por_n),
      .d_async (oc_trip_async),
      .q_sync  (oc_s)
   );

   oc_cycle_gate u_gate (
      .clk        (clk),
      .rst_n      (por_n),
      .supply_ok  (supply_ok),
      .pwm_in     (pwm_in),
      .oc_sync    (oc_s),
      .fault      (fault),
      .pwm_hs_out (pwm_hs_out),
      .evt        (evt)
   );

   oc_trunc_counter #(.LIMIT(TRIP_LIMIT)) u_count (
      .clk       (clk),
      .rst_n     (por_n),
      .supply_ok (supply_ok),
      .evt       (evt),
      .fault     (fault)
   );

   assign fault_out = fault;

   // R7: no high-side drive while a fault is held
   assert_fault_blocks_pwm_R7: assert property (@(posedge clk) disable iff (!por_n)
      fault_out |-> !pwm_hs_out);

   // R2: a synchronized trip during the high phase cuts the output
   assert_trip_cuts_R2: assert property (@(posedge clk) disable iff (!por_n)
      (pwm_in && oc_s) |-> !pwm_hs_out);

endmodule

// File: tb/oc_trunc_guard_bench.sv
module oc_trunc_guard_bench;

   localparam int CLK_PERIOD = 10;
   localparam int LIMIT      = 10;
   localparam int WATCHDOG   = 150000;

   logic clk = 1'b0;
   logic por_n = 1'b0;
   logic supply_ok = 1'b1;
   logic pwm_in = 1'b0;
   logic oc_trip_async = 1'b0;
   logic pwm_hs_out;
   logic fault_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   oc_trunc_guard #(.TRIP_LIMIT(LIMIT), .SYNC_STAGES(2)) u_oc_trunc_guard (
      .clk           (clk),
      .por_n         (por_n),
      .supply_ok     (supply_ok),
      .pwm_in        (pwm_in),
      .oc_trip_async (oc_trip_async),
      .pwm_hs_out    (pwm_hs_out),
      .fault_out     (fault_out)
   );

   // Reference state, built from the requirements
   bit m_s1, m_s2, m_pwm_d, m_cut, m_fault;
   int m_cnt;

   always @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         m_s1 = 0; m_s2 = 0; m_pwm_d = 0; m_cut = 0; m_fault = 0; m_cnt = 0;
      end else begin
         bit rise_v;
         bit old_s2;
         bit old_cut;
         rise_v  = pwm_in && !m_pwm_d;
         old_s2  = m_s2;
         old_cut = m_cut;
         m_s2 = m_s1;
         m_s1 = oc_trip_async;
         m_pwm_d = pwm_in;
         if (!supply_ok) begin
            m_cut = 0; m_cnt = 0; m_fault = 0;
         end else begin
            m_cut = (rise_v ? 1'b0 : old_cut) | (old_s2 && pwm_in);
            if (rise_v && !m_fault) begin
               if (old_cut) begin
                  if (m_cnt < LIMIT) m_cnt++;
                  if (m_cnt == LIMIT) m_fault = 1;
               end else m_cnt = 0;
            end
         end
      end
   end

   function automatic bit exp_hs();
      return pwm_in && supply_ok && !m_fault && !m_cut && !m_s2;
   endfunction

   task automatic check(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
      end
   endtask

   // Apply inputs at a falling edge, compare with the reference after the rising edge
   task automatic step(input logic p, input logic t, input logic s);
      pwm_in = p; oc_trip_async = t; supply_ok = s;
      @(posedge clk);
      #(CLK_PERIOD/4);
      check("R2 model pwm_hs_out", pwm_hs_out, exp_hs());
      check("R6 model fault_out", fault_out, m_fault);
      @(negedge clk);
   endtask

   // One PWM period: high phase then low phase, trip in the high phase when cut=1
   task automatic cut_period(input bit cut);
      for (int i = 0; i < 6; i++) step(1'b1, cut && (i == 2), 1'b1);
      for (int i = 0; i < 6; i++) step(1'b0, 1'b0, 1'b1);
   endtask

   initial begin
      void'($urandom(32'd2718));
      @(negedge clk);
      check("R8 reset pwm_hs_out", pwm_hs_out, 1'b0);
      check("R8 reset fault_out", fault_out, 1'b0);
      por_n = 1'b1;
      step(1'b0, 1'b0, 1'b1);

      // R9: trips only in the low phase never count
      for (int c = 0; c < LIMIT + 2; c++) begin
         for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b1);
         for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b1);
         step(1'b0, 1'b0, 1'b1);
         step(1'b0, 1'b0, 1'b1);
      end
      step(1'b1, 1'b0, 1'b1);
      check("R9 no fault from low-phase trips", fault_out, 1'b0);
      check("R9 output follows pwm", pwm_hs_out, 1'b1);

      // R1, R2, R3: synchronizer latency and hold-off
      step(1'b1, 1'b0, 1'b1);
      step(1'b1, 1'b1, 1'b1);
      check("R1 trip not yet visible", pwm_hs_out, 1'b1);
      step(1'b1, 1'b0, 1'b1);
      check("R2 trip cuts output", pwm_hs_out, 1'b0);
      step(1'b1, 1'b0, 1'b1);
      step(1'b1, 1'b0, 1'b1);
      check("R3 output held off after trip clears", pwm_hs_out, 1'b0);
      step(1'b0, 1'b0, 1'b1);
      step(1'b1, 1'b0, 1'b1);
      check("R3 re-enabled at next period", pwm_hs_out, 1'b1);

      // R4, R6: exactly LIMIT consecutive cut periods
      step(1'b0, 1'b0, 1'b0);
      step(1'b0, 1'b0, 1'b1);
      for (int c = 0; c < LIMIT; c++) cut_period(1'b1);
      check("R6 no fault before closing boundary", fault_out, 1'b0);
      step(1'b1, 1'b0, 1'b1);
      check("R4 fault at tenth closing boundary", fault_out, 1'b1);

      // R7: sticky fault holds output low
      for (int i = 0; i < 20; i++) step(i % 7 < 4, 1'b0, 1'b1);
      check("R7 fault held", fault_out, 1'b1);
      step(1'b1, 1'b0, 1'b1);
      check("R7 output low under fault", pwm_hs_out, 1'b0);

      // R8: supply re-cycle releases the fault
      step(1'b1, 1'b0, 1'b0);
      check("R8 fault cleared by re-cycle", fault_out, 1'b0);
      check("R8 output low while supply down", pwm_hs_out, 1'b0);
      step(1'b1, 1'b0, 1'b1);
      check("R8 fault stays clear", fault_out, 1'b0);
      check("R8 output back on", pwm_hs_out, 1'b1);

      // R5: a clean period breaks the run
      step(1'b0, 1'b0, 1'b1);
      for (int c = 0; c < LIMIT - 1; c++) cut_period(1'b1);
      cut_period(1'b0);
      for (int c = 0; c < LIMIT - 1; c++) cut_period(1'b1);
      step(1'b1, 1'b0, 1'b1);
      check("R5 run restarted, no fault", fault_out, 1'b0);
      for (int i = 0; i < 5; i++) step(1'b1, i == 1, 1'b1);
      for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 1'b1);
      step(1'b1, 1'b0, 1'b1);
      check("R5 fault after full new run", fault_out, 1'b1);

      // Mixed random periods against the reference
      for (int c = 0; c < 400; c++) begin
         int hi = $urandom_range(12, 2);
         int lo = $urandom_range(12, 2);
         int ts = ($urandom_range(99, 0) < 65) ? $urandom_range(hi + lo - 1, 0) : -1;
         int tl = $urandom_range(4, 1);
         bit down = ($urandom_range(99, 0) < 4);
         for (int i = 0; i < hi + lo; i++)
            step(i < hi, (ts >= 0) && (i >= ts) && (i < ts + tl),
                 !(down && i == hi + lo - 1));
      end

      por_n = 1'b0;
      #(CLK_PERIOD/4);
      check("R8 por clears fault", fault_out, 1'b0);
      check("R8 por clears output", pwm_hs_out, 1'b0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(WATCHDOG * CLK_PERIOD);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule